// File: doc/BRIEF.md
# Clock Stop and Power-Down Gating Controller

This block sits between a clock synthesizer and the output drivers of a system clock source. It receives five families of finished clocks (processor, 33 MHz bus, memory, 66 MHz hub and 48 MHz) and passes each output through a gate. The gates close in response to three active-low asynchronous pins and to one enable bit per output. The pins are a global power-down request, a processor-clock halt and a bus-clock halt. Each gate is held in its own clock's domain and changes only on that clock's falling edge. A gated output therefore never shows a shortened high phase, and a restarted output always begins with a complete high phase.

The power-down request is synchronized in the processor domain. It is accepted only when two consecutive synchronized samples agree, and removal is qualified the same way. While the request is accepted, every output is low, including the free-running ones, and the `pll_off` indication tells the synthesizer to shut its oscillators down. The processor halt closes only processor output 0. The bus halt closes every bus output except the free-running index 0. Memory, hub and 48 MHz outputs, including the memory-hub clock at the top memory index, have no halt pin, so only their enables and power-down affect them.

Top module: `clk_stop_ctrl`

## Requirements
- R1: A low level on `pwrdn_n` is synchronized by two `clk_cpu` flops and must then be seen on two consecutive rising edges. `pll_off` rises on the 4th `clk_cpu` rising edge after the pin falls. Processor outputs complete the high phase that starts on that edge and stay low from the following falling edge, so an enabled processor output shows exactly 4 high pulses in that window.
- R2: A low pulse on `pwrdn_n` that lasts a single `clk_cpu` period is rejected. `pll_off` stays 0 and no output loses a pulse.
- R3: While `pll_off` is 1, every output of every family is held low, including bus output 0 and the top memory output.
- R4: Release of `pwrdn_n` is qualified the same way. `pll_off` falls on the 4th `clk_cpu` rising edge after the pin rises, and the first processor high pulse comes on the 5th edge, so there are 6 pulses in 10 periods.
- R5: `cpu_halt_n` low stops only `ck_cpu_o[0]`. After two synchronizer flops it closes on the next falling edge, so there are 2 pulses in 10 periods. Release gives 8 pulses in 10 periods. Other processor outputs keep all pulses.
- R6: `pci_halt_n` low stops `ck_pci_o[PCI_W-1:1]` with the same 2-pulse and 8-pulse timing in the bus domain. `ck_pci_o[0]` never stops for this pin.
- R7: No halt pin affects the memory, hub or 48 MHz outputs. The memory-hub clock `ck_mem_o[MEM_W-1]` keeps running during both halts.
- R8: An enable bit of 0 holds its output low. The bit passes through two flops of the output's own clock, so clearing it leaves 2 pulses in 10 periods and setting it gives 8.
- R9: Every high phase of every output is a full source high phase, and no output is ever high while its source is low.
- R10: While `rst` is 1, every output is low and `pll_off` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, held for several periods of every clock |
| clk_cpu | input | 1 | Processor source clock; also clocks power-down qualification |
| clk_pci | input | 1 | 33 MHz bus source clock |
| clk_mem | input | 1 | Memory source clock |
| clk_hub | input | 1 | 66 MHz hub source clock |
| clk_usb | input | 1 | 48 MHz source clock |
| pwrdn_n | input | 1 | Asynchronous power-down request, active low |
| cpu_halt_n | input | 1 | Asynchronous halt of processor output 0, active low |
| pci_halt_n | input | 1 | Asynchronous halt of bus outputs above index 0, active low |
| en_cpu | input | CPU_W | Per-output enables, processor family |
| en_pci | input | PCI_W | Per-output enables, bus family |
| en_mem | input | MEM_W | Per-output enables, memory family |
| en_hub | input | HUB_W | Per-output enables, hub family |
| en_usb | input | USB_W | Per-output enables, 48 MHz family |
| ck_cpu_o | output | CPU_W | Gated processor clocks |
| ck_pci_o | output | PCI_W | Gated bus clocks |
| ck_mem_o | output | MEM_W | Gated memory clocks |
| ck_hub_o | output | HUB_W | Gated hub clocks |
| ck_usb_o | output | USB_W | Gated 48 MHz clocks |
| pll_off | output | 1 | Qualified power-down state; tells the synthesizer to stop |

## Verification
The bench counts high pulses of each output over fixed windows that start just after a source edge. A gate whose synchronizer is one flop short or long, or that samples on the rising edge, therefore moves the count away from 2, 8, 4 or 6. A one-period power-down glitch is applied to catch a qualifier that accepts a single sample; such a design would raise `pll_off` and drop pulses. The bench also checks that halts close only their intended bits, so a mask that includes bus output 0 or a neighbouring processor output shows up as missing pulses. A probe in the middle of each high and low phase catches any gate that switches outside the falling edge and would leave a runt.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    localparam int CPU_OUTS = 3;
    localparam int PCI_OUTS = 7;
    localparam int MEM_OUTS = 7;
    localparam int HUB_OUTS = 3;
    localparam int USB_OUTS = 2;

    // Power-down qualifier: each settled state has a "one sample seen" twin
    typedef enum logic [1:0] {
        PQ_RUN      = 2'b00,
        PQ_RUN_HIT  = 2'b01,
        PQ_DOWN     = 2'b10,
        PQ_DOWN_HIT = 2'b11
    } pd_qual_e;

    function automatic logic [31:0] ones_below(input int n);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [31:0] bit_at(input int idx);
        logic [31:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

    function automatic logic pd_is_down(input pd_qual_e s);
        return (s == PQ_DOWN) || (s == PQ_DOWN_HIT);
    endfunction

    // req = synchronized request level (1 = power-down wanted)
    function automatic pd_qual_e pd_next(input pd_qual_e s, input logic req);
        pd_qual_e n;
        case (s)
            PQ_RUN:      n = req ? PQ_RUN_HIT : PQ_RUN;
            PQ_RUN_HIT:  n = req ? PQ_DOWN    : PQ_RUN;
            PQ_DOWN:     n = req ? PQ_DOWN    : PQ_DOWN_HIT;
            PQ_DOWN_HIT: n = req ? PQ_DOWN    : PQ_RUN;
            default:     n = PQ_RUN;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/cg_gate.sv
module cg_gate (
    input  logic clk,
    input  logic rst,
    input  logic allow,
    output logic ck_o
);
    logic pass_q;

    // Opens and closes only while the source is low
    always_ff @(negedge clk) begin
        if (rst) pass_q <= 1'b0;
        else     pass_q <= allow;
    end

    assign ck_o = clk & pass_q;
endmodule

// File: rtl/cg_pd_qual.sv
module cg_pd_qual
    import clkstop_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pwrdn_n,
    output logic req_seen,
    output logic pd_state
);
    logic [0:0] pin_s;
    pd_qual_e   st_q;

    cg_sync #(.W(1), .RST_VAL(1'b1)) u_pin_sync (
        .clk (clk),
        .rst (rst),
        .d   (pwrdn_n),
        .q   (pin_s)
    );

    assign req_seen = ~pin_s[0];

    always_ff @(posedge clk) begin
        if (rst) st_q <= PQ_RUN;
        else     st_q <= pd_next(st_q, req_seen);
    end

    assign pd_state = pd_is_down(st_q);
endmodule

// File: rtl/cg_group.sv
module cg_group
    import clkstop_pkg::*;
#(
    parameter int          N         = 1,
    parameter logic [31:0] STOP_MASK = '0,
    parameter bit          HAS_STOP  = 1'b0,
    parameter bit          PD_SYNC   = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         halt_n,
    input  logic         pd_in,
    input  logic [N-1:0] en_in,
    output logic [N-1:0] ck_o,
    output logic         halt_act
);
    logic [N-1:0] en_s;
    logic         pd_act;

    cg_sync #(.W(N), .RST_VAL('0)) u_en_sync (
        .clk (clk),
        .rst (rst),
        .d   (en_in),
        .q   (en_s)
    );

    generate
        if (HAS_STOP) begin : g_halt
            logic [0:0] halt_s;
            cg_sync #(.W(1), .RST_VAL(1'b1)) u_halt_sync (
                .clk (clk),
                .rst (rst),
                .d   (halt_n),
                .q   (halt_s)
            );
            assign halt_act = ~halt_s[0];
        end else begin : g_no_halt
            logic unused_halt;
            assign unused_halt = halt_n;
            assign halt_act    = 1'b0;
        end

        if (PD_SYNC) begin : g_pd_cross
            logic [0:0] pd_s;
            cg_sync #(.W(1), .RST_VAL(1'b0)) u_pd_sync (
                .clk (clk),
                .rst (rst),
                .d   (pd_in),
                .q   (pd_s)
            );
            assign pd_act = pd_s[0];
        end else begin : g_pd_local
            assign pd_act = pd_in;
        end

        for (genvar i = 0; i < N; i++) begin : g_out
            logic allow;
            assign allow = en_s[i] & ~pd_act & ~(STOP_MASK[i] & halt_act);
            cg_gate u_gate (
                .clk   (clk),
                .rst   (rst),
                .allow (allow),
                .ck_o  (ck_o[i])
            );
        end
    endgenerate
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
    import clkstop_pkg::*;
#(
    parameter int CPU_W        = CPU_OUTS,
    parameter int PCI_W        = PCI_OUTS,
    parameter int MEM_W        = MEM_OUTS,
    parameter int HUB_W        = HUB_OUTS,
    parameter int USB_W        = USB_OUTS,
    parameter int CPU_HALT_IDX = 0,
    parameter int PCI_FREE_IDX = 0
) (
    input  logic             rst,
    input  logic             clk_cpu,
    input  logic             clk_pci,
    input  logic             clk_mem,
    input  logic             clk_hub,
    input  logic             clk_usb,
    input  logic             pwrdn_n,
    input  logic             cpu_halt_n,
    input  logic             pci_halt_n,
    input  logic [CPU_W-1:0] en_cpu,
    input  logic [PCI_W-1:0] en_pci,
    input  logic [MEM_W-1:0] en_mem,
    input  logic [HUB_W-1:0] en_hub,
    input  logic [USB_W-1:0] en_usb,
    output logic [CPU_W-1:0] ck_cpu_o,
    output logic [PCI_W-1:0] ck_pci_o,
    output logic [MEM_W-1:0] ck_mem_o,
    output logic [HUB_W-1:0] ck_hub_o,
    output logic [USB_W-1:0] ck_usb_o,
    output logic             pll_off
);
    localparam logic [31:0] CPU_HALT_MASK = bit_at(CPU_HALT_IDX);
    localparam logic [31:0] PCI_HALT_MASK = ones_below(PCI_W) & ~bit_at(PCI_FREE_IDX);

    logic pd_req_seen;
    logic pd_state;
    logic cpu_halt_act;
    logic pci_halt_act;
    logic [2:0] unused_halt_act;

    cg_pd_qual u_qual (
        .clk      (clk_cpu),
        .rst      (rst),
        .pwrdn_n  (pwrdn_n),
        .req_seen (pd_req_seen),
        .pd_state (pd_state)
    );

    assign pll_off = pd_state;

    cg_group #(.N(CPU_W), .STOP_MASK(CPU_HALT_MASK), .HAS_STOP(1'b1), .PD_SYNC(1'b0)) u_cpu (
        .clk (clk_cpu), .rst (rst), .halt_n (cpu_halt_n), .pd_in (pd_state),
        .en_in (en_cpu), .ck_o (ck_cpu_o), .halt_act (cpu_halt_act)
    );

    cg_group #(.N(PCI_W), .STOP_MASK(PCI_HALT_MASK), .HAS_STOP(1'b1), .PD_SYNC(1'b1)) u_pci (
        .clk (clk_pci), .rst (rst), .halt_n (pci_halt_n), .pd_in (pd_state),
        .en_in (en_pci), .ck_o (ck_pci_o), .halt_act (pci_halt_act)
    );

    cg_group #(.N(MEM_W), .STOP_MASK('0), .HAS_STOP(1'b0), .PD_SYNC(1'b1)) u_mem (
        .clk (clk_mem), .rst (rst), .halt_n (1'b1), .pd_in (pd_state),
        .en_in (en_mem), .ck_o (ck_mem_o), .halt_act (unused_halt_act[0])
    );

    cg_group #(.N(HUB_W), .STOP_MASK('0), .HAS_STOP(1'b0), .PD_SYNC(1'b1)) u_hub (
        .clk (clk_hub), .rst (rst), .halt_n (1'b1), .pd_in (pd_state),
        .en_in (en_hub), .ck_o (ck_hub_o), .halt_act (unused_halt_act[1])
    );

    cg_group #(.N(USB_W), .STOP_MASK('0), .HAS_STOP(1'b0), .PD_SYNC(1'b1)) u_usb (
        .clk (clk_usb), .rst (rst), .halt_n (1'b1), .pd_in (pd_state),
        .en_in (en_usb), .ck_o (ck_usb_o), .halt_act (unused_halt_act[2])
    );
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk #(
    parameter int CPU_W = 3,
    parameter int PCI_W = 7
) (
    input logic             rst,
    input logic             clk_cpu,
    input logic             clk_pci,
    input logic             pll_off,
    input logic             pd_req_seen,
    input logic             cpu_halt_act,
    input logic             pci_halt_act,
    input logic [CPU_W-1:0] ck_cpu_o,
    input logic [PCI_W-1:0] ck_pci_o
);
    // R1
    pd_enter_two_chk: assert property (@(posedge clk_cpu) disable iff (rst)
        $rose(pll_off) |-> ($past(pd_req_seen) && $past(pd_req_seen, 2)));

    // R4
    pd_leave_two_chk: assert property (@(posedge clk_cpu) disable iff (rst)
        $fell(pll_off) |-> (!$past(pd_req_seen) && !$past(pd_req_seen, 2)));

    // R3
    pd_outputs_low_chk: assert property (@(negedge clk_cpu) disable iff (rst)
        (pll_off && $past(pll_off)) |-> (ck_cpu_o == '0));

    // R5
    cpu_halt_low_chk: assert property (@(negedge clk_cpu) disable iff (rst)
        (cpu_halt_act && $past(cpu_halt_act)) |-> !ck_cpu_o[0]);

    // R6
    pci_halt_low_chk: assert property (@(negedge clk_pci) disable iff (rst)
        (pci_halt_act && $past(pci_halt_act)) |-> (ck_pci_o[PCI_W-1:1] == '0));

    // R9
    cpu_no_runt_chk: assert property (@(posedge clk_cpu) disable iff (rst)
        ck_cpu_o == '0);

    // R9
    pci_no_runt_chk: assert property (@(posedge clk_pci) disable iff (rst)
        ck_pci_o == '0);
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.CPU_W(CPU_W), .PCI_W(PCI_W)) chk_i (
    .rst          (rst),
    .clk_cpu      (clk_cpu),
    .clk_pci      (clk_pci),
    .pll_off      (pll_off),
    .pd_req_seen  (pd_req_seen),
    .cpu_halt_act (cpu_halt_act),
    .pci_halt_act (pci_halt_act),
    .ck_cpu_o     (ck_cpu_o),
    .ck_pci_o     (ck_pci_o)
);

// File: tb/clk_stop_ctrl_tb_top.sv
module clk_stop_ctrl_tb_top;
    import clkstop_pkg::*;

    localparam int CW = CPU_OUTS;
    localparam int PW = PCI_OUTS;
    localparam int MW = MEM_OUTS;
    localparam int HW = HUB_OUTS;
    localparam int UW = USB_OUTS;
    localparam int HP_CPU = 10;
    localparam int HP_PCI = 20;
    localparam int HP_MEM = 7;
    localparam int HP_HUB = 15;
    localparam int HP_USB = 11;

    logic rst = 1'b1;
    logic clk_cpu = 0, clk_pci = 0, clk_mem = 0, clk_hub = 0, clk_usb = 0;
    logic pwrdn_n = 1, cpu_halt_n = 1, pci_halt_n = 1;
    logic [CW-1:0] en_cpu = '1;
    logic [PW-1:0] en_pci = '1;
    logic [MW-1:0] en_mem = '1;
    logic [HW-1:0] en_hub = '1;
    logic [UW-1:0] en_usb = '1;
    logic [CW-1:0] ck_cpu_o;
    logic [PW-1:0] ck_pci_o;
    logic [MW-1:0] ck_mem_o;
    logic [HW-1:0] ck_hub_o;
    logic [UW-1:0] ck_usb_o;
    logic pll_off;

    always #(HP_CPU) clk_cpu = ~clk_cpu;
    always #(HP_PCI) clk_pci = ~clk_pci;
    always #(HP_MEM) clk_mem = ~clk_mem;
    always #(HP_HUB) clk_hub = ~clk_hub;
    always #(HP_USB) clk_usb = ~clk_usb;

    clk_stop_ctrl dut_i (
        .rst(rst), .clk_cpu(clk_cpu), .clk_pci(clk_pci), .clk_mem(clk_mem),
        .clk_hub(clk_hub), .clk_usb(clk_usb), .pwrdn_n(pwrdn_n),
        .cpu_halt_n(cpu_halt_n), .pci_halt_n(pci_halt_n),
        .en_cpu(en_cpu), .en_pci(en_pci), .en_mem(en_mem), .en_hub(en_hub), .en_usb(en_usb),
        .ck_cpu_o(ck_cpu_o), .ck_pci_o(ck_pci_o), .ck_mem_o(ck_mem_o),
        .ck_hub_o(ck_hub_o), .ck_usb_o(ck_usb_o), .pll_off(pll_off)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit mon_on = 0;
    int cnt_cpu [CW];
    int cnt_pci [PW];
    int cnt_mem [MW];
    int cnt_hub [HW];
    int cnt_usb [UW];
    int runt_cpu = 0, runt_pci = 0, runt_mem = 0, runt_hub = 0, runt_usb = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_ge(input string req, input int act, input int lo);
        checks++;
        if (act < lo) begin
            errors++;
            $display("FAIL %s: actual %0d expected at least %0d at %0t", req, act, lo, $time);
        end
    endtask

    task automatic clear_counts();
        for (int i = 0; i < CW; i++) cnt_cpu[i] = 0;
        for (int i = 0; i < PW; i++) cnt_pci[i] = 0;
        for (int i = 0; i < MW; i++) cnt_mem[i] = 0;
        for (int i = 0; i < HW; i++) cnt_hub[i] = 0;
        for (int i = 0; i < UW; i++) cnt_usb[i] = 0;
    endtask

    task automatic cpu_step(input int n);
        repeat (n) @(posedge clk_cpu);
        #2;
    endtask

    task automatic pci_step(input int n);
        repeat (n) @(posedge clk_pci);
        #2;
    endtask

    // Pulse counters (sampled 1 after each rising source edge) and phase probes
    always @(posedge clk_cpu) begin
        logic [CW-1:0] h;
        #1;
        for (int i = 0; i < CW; i++) if (ck_cpu_o[i] === 1'b1) cnt_cpu[i]++;
        h = ck_cpu_o;
        #(HP_CPU - 2);
        if (mon_on && ck_cpu_o !== h) runt_cpu++;
    end
    always @(negedge clk_cpu) begin
        #1; if (mon_on && ck_cpu_o !== '0) runt_cpu++;
        #(HP_CPU - 2); if (mon_on && ck_cpu_o !== '0) runt_cpu++;
    end
    always @(posedge clk_pci) begin
        logic [PW-1:0] h;
        #1;
        for (int i = 0; i < PW; i++) if (ck_pci_o[i] === 1'b1) cnt_pci[i]++;
        h = ck_pci_o;
        #(HP_PCI - 2);
        if (mon_on && ck_pci_o !== h) runt_pci++;
    end
    always @(negedge clk_pci) begin
        #1; if (mon_on && ck_pci_o !== '0) runt_pci++;
        #(HP_PCI - 2); if (mon_on && ck_pci_o !== '0) runt_pci++;
    end
    always @(posedge clk_mem) begin
        logic [MW-1:0] h;
        #1;
        for (int i = 0; i < MW; i++) if (ck_mem_o[i] === 1'b1) cnt_mem[i]++;
        h = ck_mem_o;
        #(HP_MEM - 2);
        if (mon_on && ck_mem_o !== h) runt_mem++;
    end
    always @(negedge clk_mem) begin
        #1; if (mon_on && ck_mem_o !== '0) runt_mem++;
        #(HP_MEM - 2); if (mon_on && ck_mem_o !== '0) runt_mem++;
    end
    always @(posedge clk_hub) begin
        logic [HW-1:0] h;
        #1;
        for (int i = 0; i < HW; i++) if (ck_hub_o[i] === 1'b1) cnt_hub[i]++;
        h = ck_hub_o;
        #(HP_HUB - 2);
        if (mon_on && ck_hub_o !== h) runt_hub++;
    end
    always @(negedge clk_hub) begin
        #1; if (mon_on && ck_hub_o !== '0) runt_hub++;
        #(HP_HUB - 2); if (mon_on && ck_hub_o !== '0) runt_hub++;
    end
    always @(posedge clk_usb) begin
        logic [UW-1:0] h;
        #1;
        for (int i = 0; i < UW; i++) if (ck_usb_o[i] === 1'b1) cnt_usb[i]++;
        h = ck_usb_o;
        #(HP_USB - 2);
        if (mon_on && ck_usb_o !== h) runt_usb++;
    end
    always @(negedge clk_usb) begin
        #1; if (mon_on && ck_usb_o !== '0) runt_usb++;
        #(HP_USB - 2); if (mon_on && ck_usb_o !== '0) runt_usb++;
    end

    function automatic int sum_all();
        int s;
        s = 0;
        for (int i = 0; i < CW; i++) s += cnt_cpu[i];
        for (int i = 0; i < PW; i++) s += cnt_pci[i];
        for (int i = 0; i < MW; i++) s += cnt_mem[i];
        for (int i = 0; i < HW; i++) s += cnt_hub[i];
        for (int i = 0; i < UW; i++) s += cnt_usb[i];
        return s;
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(100_000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        clear_counts();
        // R10: reset state
        cpu_step(10);
        check("R10 outputs low in reset",
              int'(|{ck_cpu_o, ck_pci_o, ck_mem_o, ck_hub_o, ck_usb_o}), 0);
        check("R10 pll_off low in reset", int'(pll_off), 0);
        rst = 1'b0;
        cpu_step(12);
        mon_on = 1'b1;

        // Baseline: everything enabled and running
        clear_counts();
        cpu_step(10);
        for (int i = 0; i < CW; i++) check("R8 enabled cpu output runs", cnt_cpu[i], 10);

        // R5: processor halt
        clear_counts();
        cpu_halt_n = 1'b0;
        cpu_step(10);
        check("R5 halted cpu0 pulses", cnt_cpu[0], 2);
        for (int i = 1; i < CW; i++) check("R5 other cpu outputs unaffected", cnt_cpu[i], 10);
        clear_counts();
        cpu_halt_n = 1'b1;
        cpu_step(10);
        check("R5 cpu0 restart pulses", cnt_cpu[0], 8);

        // R6 / R7: bus halt
        pci_step(1);
        clear_counts();
        pci_halt_n = 1'b0;
        pci_step(10);
        check("R6 free bus output keeps running", cnt_pci[0], 10);
        for (int i = 1; i < PW; i++) check("R6 halted bus output pulses", cnt_pci[i], 2);
        check("R6 cpu outputs unaffected by bus halt", cnt_cpu[0], 20);
        check_ge("R7 memory-hub clock runs during halt", cnt_mem[MW-1], 28);
        check_ge("R7 hub clock runs during halt", cnt_hub[0], 13);
        clear_counts();
        pci_halt_n = 1'b1;
        pci_step(10);
        for (int i = 1; i < PW; i++) check("R6 bus restart pulses", cnt_pci[i], 8);

        // R8: enables
        cpu_step(1);
        clear_counts();
        en_cpu[CW-1] = 1'b0;
        cpu_step(10);
        check("R8 cleared enable pulses", cnt_cpu[CW-1], 2);
        check("R8 neighbour enable untouched", cnt_cpu[0], 10);
        clear_counts();
        en_cpu[CW-1] = 1'b1;
        cpu_step(10);
        check("R8 set enable pulses", cnt_cpu[CW-1], 8);
        en_mem[MW-1] = 1'b0;
        cpu_step(10);
        clear_counts();
        cpu_step(20);
        check("R8 disabled memory-hub clock stays low", cnt_mem[MW-1], 0);
        check_ge("R8 other memory clock runs", cnt_mem[0], 28);
        en_mem[MW-1] = 1'b1;
        cpu_step(10);

        // R2: one-period glitch on power-down
        clear_counts();
        pwrdn_n = 1'b0;
        cpu_step(1);
        pwrdn_n = 1'b1;
        cpu_step(9);
        check("R2 glitch leaves pll_off low", int'(pll_off), 0);
        check("R2 glitch drops no pulse", cnt_cpu[1], 10);

        // R1: qualified entry
        clear_counts();
        pwrdn_n = 1'b0;
        cpu_step(3);
        check("R1 pll_off still low after 3 edges", int'(pll_off), 0);
        cpu_step(1);
        check("R1 pll_off high on 4th edge", int'(pll_off), 1);
        cpu_step(6);
        check("R1 cpu pulses before stop", cnt_cpu[1], 4);

        // R3: all outputs low in power-down
        cpu_step(30);
        clear_counts();
        cpu_step(20);
        check("R3 no pulse on any output", sum_all(), 0);
        check("R3 pll_off held", int'(pll_off), 1);

        // R4: qualified release
        clear_counts();
        pwrdn_n = 1'b1;
        cpu_step(3);
        check("R4 pll_off still high after 3 edges", int'(pll_off), 1);
        cpu_step(1);
        check("R4 pll_off low on 4th edge", int'(pll_off), 0);
        cpu_step(6);
        check("R4 cpu restart pulses", cnt_cpu[1], 6);
        cpu_step(30);
        clear_counts();
        cpu_step(10);
        check("R4 free bus output back", cnt_pci[0], 5);

        // R9: no shortened phases anywhere
        check("R9 cpu phases", runt_cpu, 0);
        check("R9 bus phases", runt_pci, 0);
        check("R9 memory phases", runt_mem, 0);
        check("R9 hub phases", runt_hub, 0);
        check("R9 48 MHz phases", runt_usb, 0);

        done = 1'b1;
        finish_run();
    end
endmodule